// File: doc/BRIEF.md
# Destination Cast Type Drop Counters

This block sorts every received packet by the kind of destination it targets and keeps a tally of how many packets of each kind were discarded by an upstream congestion-driven early-drop stage. There are four kinds: link-layer multicast, link-layer broadcast, network-layer multicast and network-layer broadcast. Each kind has a saturating counter. The classification is gated by the packet's parse mode. A link-layer multicast never includes a link-layer broadcast.

The parser supplies the destination MAC, an IP flag, an IPv4/IPv6 selector, the destination IP address and the parse mode. The drop stage marks each packet's final cycle with `pktDone`, and raises `pktDrop` in that same cycle if it discarded the packet. Software-side logic reads the counters through a small read port. On that port, a counter can optionally be cleared as it is read.

Top module: `cast_drop_counters`

## Requirements
- R1: A packet whose 48-bit destination MAC is all ones is link-layer broadcast and, when counted, increments counter 1 (rdAddr = 1).
- R2: A packet is link-layer multicast when `dstMac[40]` is set and the MAC is not all ones. Such a packet increments counter 0 (rdAddr = 0), and no packet increments both counter 0 and counter 1.
- R3: Link-layer classes are counted only when parseMode = 1 (skip-to-L2). Mode 0 is no parse, mode 2 is skip-to-IP and mode 3 is reserved.
- R4: An IPv4 destination (in `dstIp[31:0]`, with `ipIsV6` = 0) whose top nibble `dstIp[31:28]` is 0xE is network-layer multicast and increments counter 2 (rdAddr = 2).
- R5: An IPv4 destination whose top byte `dstIp[31:24]` is 0xFF is network-layer broadcast. It increments counter 3 (rdAddr = 3) and not counter 2.
- R6: An IPv6 destination (`ipIsV6` = 1) whose top byte `dstIp[127:120]` is 0xFF increments counter 2. An IPv6 packet never increments counter 3.
- R7: Network-layer classes are counted only when parseMode = 1 with `ipValid` = 1, or when parseMode = 2. In mode 2 the value of `ipValid` does not matter.
- R8: A counter increments only on a cycle where `pktDone` and `pktDrop` are both high. The new value is visible to a read issued from the next cycle on.
- R9: With parseMode = 3 or parseMode = 0, no counter changes.
- R10: After reset, all counters and `rdData` are zero. A read with `rdEn` high loads the value of counter `rdAddr` into `rdData` at that clock edge, and `rdData` holds it until the next read.
- R11: A read with `clrOnRead` high returns the old value and zeroes that counter. If an increment of the same counter arrives in that cycle, the counter becomes 1.
- R12: Counters saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktDone | input | 1 | Final cycle of a packet's drop decision |
| pktDrop | input | 1 | Packet was discarded by early drop (valid with pktDone) |
| parseMode | input | 2 | 0 none, 1 skip-to-L2, 2 skip-to-IP, 3 reserved |
| dstMac | input | 48 | Destination MAC, first transmitted byte in bits 47:40 |
| ipValid | input | 1 | Packet carries an IP header |
| ipIsV6 | input | 1 | 1 = IPv6 address, 0 = IPv4 address in bits 31:0 |
| dstIp | input | 128 | Destination IP address |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 2 | Counter select: 0 L2 mcast, 1 L2 bcast, 2 L3 mcast, 3 L3 bcast |
| clrOnRead | input | 1 | Zero the selected counter as it is read |
| rdData | output | CNT_W (32) | Value returned by the last read |

## Verification
Addresses are driven on both sides of each classification boundary, and each pair separates one rule from its neighbour. An all-ones MAC is paired with a MAC that has only the group bit set, to separate broadcast from multicast. IPv4 0xE0, 0xF0 and 0xFF top bytes separate the nibble test from the byte test. An IPv6 0xFF address checks that it lands in multicast and never in broadcast. The same addresses are replayed under every parse mode, with `ipValid` toggled, and with `pktDone` and `pktDrop` each held alone, so that each gate is shown to block counting. Plain reads, clearing reads, a clearing read that collides with an increment, and a long drop run that passes the counter limit cover the read and saturation rules.

// File: rtl/cast_pkg.sv
package cast_pkg;

  localparam int CLS_N     = 4;
  localparam int CLS_IDX_W = $clog2(CLS_N);

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_L2   = 2'd1,
    PM_IP   = 2'd2,
    PM_RSVD = 2'd3
  } parseMode_e;

  typedef enum logic [CLS_IDX_W-1:0] {
    CLS_L2_MC = 2'd0,
    CLS_L2_BC = 2'd1,
    CLS_L3_MC = 2'd2,
    CLS_L3_BC = 2'd3
  } castClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [CLS_N-1:0]     inc;
    logic [CLS_N-1:0]     clr;
    logic                 rd;
    logic [CLS_IDX_W-1:0] sel;
  } castStrobes_t;

endpackage

// File: rtl/cast_ctrl.sv
module cast_ctrl
  import cast_pkg::*;
#(
  parameter int MAC_W = 48,
  parameter int IP_W  = 128,
  parameter int V4_W  = 32
) (
  input  logic                 pktDone,
  input  logic                 pktDrop,
  input  logic [1:0]           parseMode,
  input  logic [MAC_W-1:0]     dstMac,
  input  logic                 ipValid,
  input  logic                 ipIsV6,
  input  logic [IP_W-1:0]      dstIp,
  input  logic                 rdEn,
  input  logic [CLS_IDX_W-1:0] rdAddr,
  input  logic                 clrOnRead,
  output castStrobes_t         strobes
);

  // group bit: LSB of the first transmitted byte
  localparam int GROUP_BIT = MAC_W - 8;

  logic       dropHit;
  logic       l2Mode;
  logic       l3On;
  logic       macBcast;
  logic       macMcast;
  logic [7:0] v4Top;
  logic [7:0] v6Top;
  logic       l3Mcast;
  logic       l3Bcast;

  always_comb begin
    dropHit  = pktDone && pktDrop;
    l2Mode   = (parseMode == PM_L2);
    l3On     = (l2Mode && ipValid) || (parseMode == PM_IP);

    macBcast = &dstMac;
    macMcast = dstMac[GROUP_BIT] && !macBcast;

    v4Top    = dstIp[V4_W-1 -: 8];
    v6Top    = dstIp[IP_W-1 -: 8];
    l3Mcast  = ipIsV6 ? (v6Top == 8'hFF) : (v4Top[7:4] == 4'hE);
    l3Bcast  = !ipIsV6 && (v4Top == 8'hFF);
  end

  always_comb begin
    strobes = '0;
    strobes.inc[CLS_L2_MC] = dropHit && l2Mode && macMcast;
    strobes.inc[CLS_L2_BC] = dropHit && l2Mode && macBcast;
    strobes.inc[CLS_L3_MC] = dropHit && l3On && l3Mcast;
    strobes.inc[CLS_L3_BC] = dropHit && l3On && l3Bcast;
    strobes.rd  = rdEn;
    strobes.sel = rdAddr;
    for (int i = 0; i < CLS_N; i++) begin
      strobes.clr[i] = rdEn && clrOnRead && (rdAddr == CLS_IDX_W'(i));
    end
  end

endmodule

// File: rtl/cast_sat_counter.sv
module cast_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= '0;
    end else if (clr) begin
      value <= inc ? CNT_ONE : '0;
    end else if (inc && (value != CNT_MAX)) begin
      value <= value + CNT_ONE;
    end
  end

endmodule

// File: rtl/cast_dpath.sv
module cast_dpath
  import cast_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  castStrobes_t     strobes,
  output logic [CNT_W-1:0] rdData
);

  logic [CNT_W-1:0] cntVal [CLS_N];

  for (genvar g = 0; g < CLS_N; g++) begin : gen_cnt
    cast_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (strobes.inc[g]),
      .clr   (strobes.clr[g]),
      .value (cntVal[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rd) begin
      rdData <= cntVal[strobes.sel];
    end
  end

endmodule

// File: rtl/cast_drop_counters.sv
module cast_drop_counters
  import cast_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int MAC_W = 48,
  parameter int IP_W  = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktDone,
  input  logic             pktDrop,
  input  logic [1:0]       parseMode,
  input  logic [MAC_W-1:0] dstMac,
  input  logic             ipValid,
  input  logic             ipIsV6,
  input  logic [IP_W-1:0]  dstIp,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  input  logic             clrOnRead,
  output logic [CNT_W-1:0] rdData
);

  castStrobes_t strobes;

  cast_ctrl #(.MAC_W(MAC_W), .IP_W(IP_W)) u_ctrl (
    .pktDone   (pktDone),
    .pktDrop   (pktDrop),
    .parseMode (parseMode),
    .dstMac    (dstMac),
    .ipValid   (ipValid),
    .ipIsV6    (ipIsV6),
    .dstIp     (dstIp),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .clrOnRead (clrOnRead),
    .strobes   (strobes)
  );

  cast_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdData  (rdData)
  );

endmodule

// File: rtl/cast_drop_counters_chk.sv
module cast_drop_counters_chk
  import cast_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             pktDone,
  input logic             pktDrop,
  input logic [1:0]       parseMode,
  input logic             ipIsV6,
  input logic             rdEn,
  input castStrobes_t     strobes,
  input logic [CNT_W-1:0] rdData
);

  // R2
  l2_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.inc[CLS_L2_MC] && strobes.inc[CLS_L2_BC]));

  // R3
  l2_mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parseMode != PM_L2) |-> (strobes.inc[CLS_L2_BC:CLS_L2_MC] == 2'b00));

  // R5
  l3_bcast_not_mcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.inc[CLS_L3_BC] && !ipIsV6) |-> !strobes.inc[CLS_L3_MC]);

  // R6
  v6_no_bcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    ipIsV6 |-> !strobes.inc[CLS_L3_BC]);

  // R8
  drop_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pktDone && pktDrop) |-> (strobes.inc == '0));

  // R9
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((parseMode == PM_RSVD) || (parseMode == PM_NONE)) |-> (strobes.inc == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind cast_drop_counters cast_drop_counters_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pktDone   (pktDone),
  .pktDrop   (pktDrop),
  .parseMode (parseMode),
  .ipIsV6    (ipIsV6),
  .rdEn      (rdEn),
  .strobes   (strobes),
  .rdData    (rdData)
);

// File: tb/cast_drop_counters_tb.sv
`timescale 1ns/1ps
module cast_drop_counters_tb;

  localparam int CW = 8;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pktDone = 1'b0;
  logic          pktDrop = 1'b0;
  logic [1:0]    parseMode = 2'd0;
  logic [47:0]   dstMac = '0;
  logic          ipValid = 1'b0;
  logic          ipIsV6 = 1'b0;
  logic [127:0]  dstIp = '0;
  logic          rdEn = 1'b0;
  logic [1:0]    rdAddr = 2'd0;
  logic          clrOnRead = 1'b0;
  logic [CW-1:0] rdData;

  always #2.5 clk = ~clk;

  cast_drop_counters #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .pktDone(pktDone), .pktDrop(pktDrop),
    .parseMode(parseMode), .dstMac(dstMac), .ipValid(ipValid),
    .ipIsV6(ipIsV6), .dstIp(dstIp), .rdEn(rdEn), .rdAddr(rdAddr),
    .clrOnRead(clrOnRead), .rdData(rdData)
  );

  typedef struct {
    logic [CW-1:0] exp;
    string         tag;
  } expItem_t;

  expItem_t      sbq[$];
  logic [CW-1:0] model [4];
  int            checks = 0;
  int            fails = 0;
  logic          sampledRd = 1'b0;
  bit            finished = 1'b0;

  localparam logic [47:0] MAC_BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MAC_MC  = 48'h0100_5E00_0001;
  localparam logic [47:0] MAC_UC  = 48'h0200_0000_0001;
  localparam logic [127:0] V4_MC  = {96'h0, 32'hE000_0001};
  localparam logic [127:0] V4_BC  = {96'h0, 32'hFF00_0000};
  localparam logic [127:0] V4_F0  = {96'h0, 32'hF000_0001};
  localparam logic [127:0] V4_UC  = {96'h0, 32'h0A00_0001};
  localparam logic [127:0] V6_MC  = {8'hFF, 120'h1};
  localparam logic [127:0] V6_UC  = {8'h20, 120'h1};

  // independent reference of the classification rules
  function automatic logic [3:0] refClass(input logic [1:0] m, input logic [47:0] mac,
                                          input logic ipv, input logic v6,
                                          input logic [127:0] ip);
    logic [3:0] r;
    logic l3;
    r = 4'b0;
    if (m == 2'd1) begin
      if (mac == MAC_BC) r[1] = 1'b1;
      else if (mac[40]) r[0] = 1'b1;
    end
    l3 = (m == 2'd1 && ipv) || (m == 2'd2);
    if (l3) begin
      if (v6) r[2] = (ip[127:120] == 8'hFF);
      else begin
        r[2] = (ip[31:28] == 4'hE);
        r[3] = (ip[31:24] == 8'hFF);
      end
    end
    return r;
  endfunction

  task automatic driveCycle(input logic done, input logic drop, input logic [1:0] m,
                            input logic [47:0] mac, input logic ipv, input logic v6,
                            input logic [127:0] ip, input logic rd, input logic [1:0] a,
                            input logic clr, input string tag);
    logic [3:0] cls;
    expItem_t it;
    @(negedge clk);
    pktDone = done; pktDrop = drop; parseMode = m; dstMac = mac;
    ipValid = ipv; ipIsV6 = v6; dstIp = ip;
    rdEn = rd; rdAddr = a; clrOnRead = clr;
    if (rd) begin
      it.exp = model[a];
      it.tag = tag;
      sbq.push_back(it);
      if (clr) model[a] = '0;
    end
    cls = (done && drop) ? refClass(m, mac, ipv, v6, ip) : 4'b0;
    for (int i = 0; i < 4; i++) begin
      if (cls[i] && model[i] != CMAX) model[i] = model[i] + 1'b1;
    end
  endtask

  task automatic sendPkt(input logic done, input logic drop, input logic [1:0] m,
                         input logic [47:0] mac, input logic ipv, input logic v6,
                         input logic [127:0] ip);
    driveCycle(done, drop, m, mac, ipv, v6, ip, 1'b0, 2'd0, 1'b0, "");
  endtask

  task automatic readCnt(input logic [1:0] a, input logic clr, input string tag);
    driveCycle(1'b0, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b1, a, clr, tag);
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 4; i++) readCnt(2'(i), 1'b0, tag);
  endtask

  task automatic idle();
    driveCycle(1'b0, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0, 1'b0, 2'd0, 1'b0, "");
  endtask

  // monitor
  always @(posedge clk) sampledRd <= rdEn;

  always @(negedge clk) begin
    if (sampledRd && rstN) begin
      expItem_t it;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL monitor: read result with no expected item, actual=%0d", rdData);
      end else begin
        it = sbq.pop_front();
        checks++;
        if (rdData !== it.exp) begin
          fails++;
          $display("FAIL %s: actual=%0d expected=%0d", it.tag, rdData, it.exp);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rdData !== '0) begin
      fails++;
      $display("FAIL R10 reset rdData: actual=%0d expected=0", rdData);
    end
    rstN = 1'b1;

    // R10: reset values
    readAll("R10 reset counter");

    // R1 / R2: link-layer broadcast versus multicast
    sendPkt(1, 1, 2'd1, MAC_BC, 1'b0, 1'b0, V4_UC);
    sendPkt(1, 1, 2'd1, MAC_MC, 1'b0, 1'b0, V4_UC);
    sendPkt(1, 1, 2'd1, MAC_MC, 1'b0, 1'b0, V4_UC);
    sendPkt(1, 1, 2'd1, MAC_UC, 1'b0, 1'b0, V4_UC);
    readCnt(2'd1, 1'b0, "R1 L2 broadcast");
    readCnt(2'd0, 1'b0, "R2 L2 multicast");

    // R3: link-layer classes blocked outside skip-to-L2
    sendPkt(1, 1, 2'd2, MAC_BC, 1'b0, 1'b0, V4_UC);
    sendPkt(1, 1, 2'd2, MAC_MC, 1'b0, 1'b0, V4_UC);
    sendPkt(1, 1, 2'd0, MAC_BC, 1'b0, 1'b0, V4_UC);
    readCnt(2'd1, 1'b0, "R3 L2 bcast gated by mode");
    readCnt(2'd0, 1'b0, "R3 L2 mcast gated by mode");

    // R4 / R5: IPv4
    sendPkt(1, 1, 2'd2, MAC_UC, 1'b0, 1'b0, V4_MC);
    sendPkt(1, 1, 2'd1, MAC_UC, 1'b1, 1'b0, V4_BC);
    sendPkt(1, 1, 2'd1, MAC_UC, 1'b1, 1'b0, V4_F0);
    readCnt(2'd2, 1'b0, "R4 IPv4 multicast");
    readCnt(2'd3, 1'b0, "R5 IPv4 broadcast");

    // R6: IPv6
    sendPkt(1, 1, 2'd2, MAC_UC, 1'b1, 1'b1, V6_MC);
    sendPkt(1, 1, 2'd1, MAC_UC, 1'b1, 1'b1, V6_UC);
    readCnt(2'd2, 1'b0, "R6 IPv6 multicast");
    readCnt(2'd3, 1'b0, "R6 IPv6 never broadcast");

    // R7: network-layer gating
    sendPkt(1, 1, 2'd1, MAC_UC, 1'b0, 1'b0, V4_MC);
    sendPkt(1, 1, 2'd1, MAC_UC, 1'b0, 1'b0, V4_BC);
    sendPkt(1, 1, 2'd2, MAC_UC, 1'b0, 1'b0, V4_BC);
    readCnt(2'd2, 1'b0, "R7 L3 mcast gating");
    readCnt(2'd3, 1'b0, "R7 L3 bcast gating");

    // R8: both strobes needed
    sendPkt(1, 0, 2'd1, MAC_BC, 1'b1, 1'b0, V4_BC);
    sendPkt(0, 1, 2'd1, MAC_BC, 1'b1, 1'b0, V4_BC);
    readAll("R8 drop and done required");

    // R9: reserved and no-parse modes
    sendPkt(1, 1, 2'd3, MAC_BC, 1'b1, 1'b0, V4_BC);
    sendPkt(1, 1, 2'd3, MAC_MC, 1'b1, 1'b0, V4_MC);
    sendPkt(1, 1, 2'd0, MAC_MC, 1'b1, 1'b0, V4_MC);
    readAll("R9 idle modes");

    // R8: increment visible to a read in the next cycle
    sendPkt(1, 1, 2'd1, MAC_BC, 1'b0, 1'b0, V4_UC);
    readCnt(2'd1, 1'b0, "R8 next-cycle visibility");

    // R10: repeated plain read, then hold
    readCnt(2'd1, 1'b0, "R10 plain read");
    idle(); idle();

    // R11: clear on read
    readCnt(2'd0, 1'b1, "R11 clear-on-read returns old");
    readCnt(2'd0, 1'b0, "R11 cleared to zero");
    driveCycle(1, 1, 2'd1, MAC_BC, 1'b0, 1'b0, V4_UC, 1'b1, 2'd1, 1'b1,
               "R11 clear with collision returns old");
    readCnt(2'd1, 1'b0, "R11 collision leaves one");

    // R12: saturation
    for (int i = 0; i < 260; i++) sendPkt(1, 1, 2'd2, MAC_UC, 1'b0, 1'b0, V4_MC);
    readCnt(2'd2, 1'b0, "R12 saturate");
    sendPkt(1, 1, 2'd2, MAC_UC, 1'b0, 1'b0, V4_MC);
    readCnt(2'd2, 1'b0, "R12 stays saturated");

    idle(); idle(); idle();
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL monitor: %0d reads without result, expected 0", sbq.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule